// File: doc/BRIEF.md
# Pipelined Burst Static RAM Front End

This block is the synchronous control and storage front end of a pipelined static RAM with a 36-bit word. The word is split into four 9-bit byte lanes. Every rising clock edge samples the address, the chip selects, the two start strobes, the advance input and the write controls. A burst begins on either of two strobes: a processor-side strobe that starts as a read, or a controller-side strobe that can write at once. Each start loads the two low address bits into a wraparound beat counter. That counter then steps through four word offsets in either linear or interleaved order, while the upper address bits stay fixed.

Read data passes through a registered output stage. Write data is written to the small behavioural array held inside the block. A separate output-enable signal marks the cycles in which the data outputs would be driven, so a surrounding model can represent the high-impedance state. A sleep input forces the block into a power-down state.

Top module: `pbsram_ctrl`

## Requirements
- R1: On a selected start, address bits [1:0] become the first beat offset and bits [ADDR_W-1:2] are held for every beat of that burst.
- R2: With `seq_mode` low the beat offset is (start + n) mod 4; with `seq_mode` high it is start XOR n, where n is the number of advances since the start.
- R3: A start takes effect only when `cs1_n` is low, `cs2` is high and `cs3_n` is low, and `addr` is sampled only on an edge where a start strobe is low.
- R4: A start strobe seen while the selects are inactive is a deselect: that edge performs no access, and any running burst ends, so no further data is driven until the next selected start.
- R5: A start from `proc_start_n` is always a read of the start address; its write controls are ignored, and the write controls sampled on the following edge (with `burst_adv_n` high) write that same address.
- R6: When `glob_wr_n` is low, an access writes all four lanes, whatever `byte_wr_en_n` and `lane_wr_n` hold.
- R7: With `glob_wr_n` high and `byte_wr_en_n` low, lane i (bits 9i+8..9i) is written exactly when `lane_wr_n[i]` is low; if `byte_wr_en_n` is high or every `lane_wr_n` bit is high, the access is a read.
- R8: Without a start strobe, a running burst advances one beat when `burst_adv_n` is low and repeats the same beat when it is high; after four advances it returns to the start offset.
- R9: Data read on the edge that samples an access appears on `dout` after the next rising edge.
- R10: `proc_start_n` is ignored while `cs1_n` is high, and a running burst then continues; `ctrl_start_n` is evaluated in every case and takes precedence when both strobes are low.
- R11: `dout_oe` is high only when `out_en_n` is low, `sleep` is low, and the output stage holds read data.
- R12: While `sleep` is high, no access or write occurs, any burst ends, and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| sleep | input | 1 | Power-down request, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| proc_start_n | input | 1 | Processor-side burst start, active low |
| ctrl_start_n | input | 1 | Controller-side burst start, active low |
| burst_adv_n | input | 1 | Advance to the next beat, active low |
| seq_mode | input | 1 | Static beat order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_en_n | input | 1 | Qualifies per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | High when the data outputs are driven |

## Verification
The bench walks bursts that start at offsets 1 and 2 in both orders. If the order were wrong, or the counter did not wrap, the stream would show the wrong words. It mixes suspended beats into a burst, where a counter that stepped anyway would skip a word. It starts a processor-side burst with the write controls active. A design that wrote on that first edge would corrupt the word, and one that ignored the second edge would leave it unchanged. The bench also sends a processor strobe with `cs1_n` high in mid-burst, sends strobes with the selects inactive, sets output enable high and sleep high, writes a partial lane mask and a global write against a conflicting mask, and sends a byte-enable that is not qualified. Each case is judged through later readback or through `dout_oe`.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/pbsram_burst_seq.sv
module pbsram_burst_seq #(
    parameter int OW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          interleave,
    input  logic [OW-1:0] start_ofs,
    output logic [OW-1:0] ofs_d
);
    typedef struct packed {
        logic [OW-1:0] start;
        logic [OW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.start = start_ofs;
            s_d.cnt   = '0;
        end else if (step) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        ofs_d = interleave ? (s_d.start ^ s_d.cnt) : (s_d.start + s_d.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1
    load_captures_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (s_q.start == $past(start_ofs)) && (s_q.cnt == '0));

    // R8
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(s_q));
endmodule

// File: rtl/pbsram_lane_dec.sv
module pbsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             glob_wr_n,
    input  logic             byte_wr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !glob_wr_n || (!byte_wr_en_n && !lane_wr_n[i]);
    end
endmodule

// File: rtl/pbsram_store.sv
module pbsram_store #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic                    rd,
    input  logic [AW-1:0]           a,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_vld
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;
    logic          vld_q;

    always_ff @(posedge clk) begin
        if (wr) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lanes[i]) mem[a][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
        if (rd) rdata_q <= mem[a];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= rd;
    end

    assign rdata  = rdata_q;
    assign rd_vld = vld_q;

    // R9
    read_one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_vld);
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    proc_start_n,
    input  logic                    ctrl_start_n,
    input  logic                    burst_adv_n,
    input  logic                    seq_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    glob_wr_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              active;
        logic [HI_W-1:0]   hi;
        acc_kind_e         kind;
        logic [ADDR_W-1:0] a;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              sel, strobe_c, strobe_p, strobe, load, step;
    logic [LANES-1:0]  lane_we;
    logic [BEAT_W-1:0] ofs_d;
    logic              rd_vld;

    pbsram_lane_dec #(.LANES(LANES)) u_lane_dec (
        .glob_wr_n    (glob_wr_n),
        .byte_wr_en_n (byte_wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .lane_we      (lane_we)
    );

    pbsram_burst_seq #(.OW(BEAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .interleave (seq_mode),
        .start_ofs  (addr[BEAT_W-1:0]),
        .ofs_d      (ofs_d)
    );

    always_comb begin
        sel      = !cs1_n && cs2 && !cs3_n;
        strobe_c = !ctrl_start_n;
        strobe_p = ctrl_start_n && !proc_start_n && !cs1_n;
        strobe   = strobe_c || strobe_p;
        load     = !sleep && strobe && sel;
        step     = !sleep && !strobe && s_q.active && !burst_adv_n;

        s_d       = s_q;
        s_d.kind  = ACC_NONE;
        s_d.lanes = '0;
        s_d.data  = din;
        if (sleep) begin
            s_d.active = 1'b0;
        end else if (strobe) begin
            s_d.active = sel;
            if (sel) begin
                s_d.hi   = addr[ADDR_W-1:BEAT_W];
                s_d.kind = (strobe_c && (|lane_we)) ? ACC_WRITE : ACC_READ;
            end
        end else if (s_q.active) begin
            s_d.kind = (|lane_we) ? ACC_WRITE : ACC_READ;
        end
        if (s_d.kind == ACC_WRITE) s_d.lanes = lane_we;
        s_d.a = {s_d.hi, ofs_d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    pbsram_store #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (s_q.kind == ACC_WRITE),
        .wr_lanes (s_q.lanes),
        .rd       (s_q.kind == ACC_READ),
        .a        (s_q.a),
        .wdata    (s_q.data),
        .rdata    (dout),
        .rd_vld   (rd_vld)
    );

    assign dout_oe = rd_vld && !out_en_n && !sleep;

    // R12
    sleep_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s_q.kind == ACC_NONE) && !s_q.active);

    // R11
    oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!out_en_n && !sleep));

    // R6
    global_write_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ctrl_start_n && !cs1_n && cs2 && !cs3_n && !glob_wr_n)
        |=> (s_q.kind == ACC_WRITE) && (&s_q.lanes));

    // R4
    deselect_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ctrl_start_n && !(!cs1_n && cs2 && !cs3_n))
        |=> !s_q.active && (s_q.kind == ACC_NONE));

    // R5
    proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ctrl_start_n && !proc_start_n && !cs1_n && cs2 && !cs3_n)
        |=> (s_q.kind == ACC_READ));
endmodule

// File: tb/pbsram_ctrl_bench.sv
module pbsram_ctrl_bench;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          sleep, cs1_n, cs2, cs3_n, proc_start_n, ctrl_start_n, burst_adv_n, seq_mode;
    logic [AW-1:0] addr;
    logic          glob_wr_n, byte_wr_en_n, out_en_n;
    logic [LN-1:0] lane_wr_n;
    logic [DW-1:0] din, dout;
    logic          dout_oe;

    pbsram_ctrl u_pbsram_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n), .burst_adv_n(burst_adv_n),
        .seq_mode(seq_mode), .addr(addr), .glob_wr_n(glob_wr_n), .byte_wr_en_n(byte_wr_en_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        int            due;
        bit            rd;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0, pcnt = 0;
    bit   done = 1'b0;

    logic [DW-1:0]    mm [1 << AW];
    bit               m_act = 1'b0;
    logic [AW-3:0]    m_hi = '0;
    logic [1:0]       m_st = '0, m_cnt = '0;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        sleep = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
        proc_start_n = 1; ctrl_start_n = 1; burst_adv_n = 1;
        glob_wr_n = 1; byte_wr_en_n = 1; lane_wr_n = '1;
        out_en_n = 0; addr = '0; din = '0;
    endtask

    // Reference model built from the requirements; one call per clock.
    task automatic tick(input string req);
        bit            sel, sc, sp, isw, isr;
        logic [LN-1:0] we;
        logic [1:0]    ofs;
        logic [AW-1:0] a;
        exp_t          e;
        sel = !cs1_n && cs2 && !cs3_n;
        sc  = !ctrl_start_n;
        sp  = ctrl_start_n && !proc_start_n && !cs1_n;
        for (int i = 0; i < LN; i++) we[i] = !glob_wr_n || (!byte_wr_en_n && !lane_wr_n[i]);
        isw = 0; isr = 0;
        if (sleep) m_act = 0;
        else if (sc || sp) begin
            m_act = sel;
            if (sel) begin
                m_hi = addr[AW-1:2]; m_st = addr[1:0]; m_cnt = 0;
                if (sc && we != 0) isw = 1; else isr = 1;
            end
        end else if (m_act) begin
            if (!burst_adv_n) m_cnt = m_cnt + 1;
            if (we != 0) isw = 1; else isr = 1;
        end
        ofs = seq_mode ? (m_st ^ m_cnt) : (m_st + m_cnt);
        a = {m_hi, ofs};
        if (isw)
            for (int i = 0; i < LN; i++) if (we[i]) mm[a][i*LW +: LW] = din[i*LW +: LW];
        e.due = pcnt + 2; e.rd = isr; e.data = isr ? mm[a] : '0; e.req = req;
        q.push_back(e);
        @(negedge clk);
        idle_inputs();
    endtask

    // Monitor: compares each due item shortly after the edge that loads dout.
    initial begin
        forever begin
            @(posedge clk);
            pcnt++;
            #4;
            while (q.size() > 0 && q[0].due == pcnt) begin
                exp_t e;
                bit   eo;
                e  = q.pop_front();
                eo = e.rd && !out_en_n && !sleep;
                chk({e.req, " oe"}, DW'(dout_oe), DW'(eo));
                if (eo) chk({e.req, " data"}, dout, e.data);
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(64'h9E37_79B9_7F4A_7C15 * (k + 3));
    endfunction

    initial begin
        idle_inputs();
        seq_mode = 0;
        repeat (3) @(negedge clk);
        chk("reset oe", DW'(dout_oe), '0);
        rst_n = 1;
        @(negedge clk);

        // Fill with global writes (R6)
        for (int k = 0; k < (1 << AW); k++) begin
            ctrl_start_n = 0; glob_wr_n = 0; addr = AW'(k); din = pat(k);
            tick("R6 fill");
        end
        // Single read latency (R9)
        ctrl_start_n = 0; addr = 6'd5; tick("R9 single read");
        // Linear burst from offset 2 with wrap (R1 R2 R8)
        seq_mode = 0;
        ctrl_start_n = 0; addr = 6'd10; tick("R1 start");
        burst_adv_n = 0; addr = 6'd63; tick("R3 addr ignored");
        burst_adv_n = 0; tick("R2 linear");
        burst_adv_n = 0; tick("R2 linear");
        burst_adv_n = 0; tick("R8 wrap");
        // Interleaved from offset 1 with suspend (R2 R8)
        seq_mode = 1;
        ctrl_start_n = 0; addr = 6'd17; tick("R1 start");
        burst_adv_n = 0; tick("R2 interleaved");
        burst_adv_n = 0; tick("R2 interleaved");
        tick("R8 suspend");
        burst_adv_n = 0; tick("R2 interleaved");
        burst_adv_n = 0; tick("R8 wrap");
        seq_mode = 0;
        // Partial lane write (R7)
        ctrl_start_n = 0; addr = 6'd20; byte_wr_en_n = 0; lane_wr_n = 4'b1010; din = '1; tick("R7 lanes");
        ctrl_start_n = 0; addr = 6'd20; tick("R7 readback");
        // Unqualified lane selects are a read (R7)
        ctrl_start_n = 0; addr = 6'd21; lane_wr_n = '0; din = '0; tick("R7 no qualify");
        ctrl_start_n = 0; addr = 6'd21; tick("R7 unchanged");
        // Global write beats lane mask (R6)
        ctrl_start_n = 0; addr = 6'd22; glob_wr_n = 0; byte_wr_en_n = 0; lane_wr_n = '1;
        din = pat(100); tick("R6 override");
        ctrl_start_n = 0; addr = 6'd22; tick("R6 readback");
        // Processor start: read first, write on second edge (R5)
        proc_start_n = 0; addr = 6'd30; glob_wr_n = 0; din = pat(200); tick("R5 first read");
        glob_wr_n = 0; din = pat(201); tick("R5 second edge");
        ctrl_start_n = 0; addr = 6'd30; tick("R5 readback");
        // Deselects (R3 R4)
        ctrl_start_n = 0; cs2 = 0; addr = 6'd40; tick("R4 deselect");
        tick("R4 burst ended");
        proc_start_n = 0; cs3_n = 1; addr = 6'd41; tick("R3 inactive select");
        tick("R4 still idle");
        // Processor strobe ignored with cs1_n high; controller strobe deselects (R10)
        ctrl_start_n = 0; addr = 6'd44; tick("R10 start");
        proc_start_n = 0; cs1_n = 1; burst_adv_n = 0; addr = 6'd50; tick("R10 ignored");
        ctrl_start_n = 0; proc_start_n = 0; addr = 6'd8; tick("R10 priority");
        ctrl_start_n = 0; cs1_n = 1; tick("R10 deselect");
        // Output enable (R11)
        ctrl_start_n = 0; addr = 6'd5; tick("R11 read");
        out_en_n = 1; tick("R11 oe high");
        out_en_n = 1; tick("R11 oe high");
        // Sleep blocks writes (R12)
        sleep = 1; ctrl_start_n = 0; glob_wr_n = 0; addr = 6'd5; din = '0; tick("R12 sleep");
        sleep = 1; tick("R12 sleep");
        ctrl_start_n = 0; addr = 6'd5; tick("R12 readback");
        ctrl_start_n = 0; cs2 = 0; tick("R4 final");
        repeat (4) tick("drain");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog got=timeout exp=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule